// File: doc/BRIEF.md
# Multiplexed-Bus Burst Read Target

This block is the responding side of a synchronous bus on which address and data share one set of lines. An initiator opens a transaction by raising a transaction-active line and placing an address on the shared lines and a command code on the command/byte-enable lines, all in the same cycle. If the command is an I/O read and the address falls inside this target's window, the target claims the transaction. It leaves the shared lines undriven for one turnaround cycle and then may hold off for a fixed number of wait cycles. After that it returns words from an internal register array, one word for each clock on which both sides signal ready.

A burst continues until the initiator drops the transaction-active line during its final data phase. The target then releases its claim, its ready and its output enable after that phase completes. Tri-state behaviour is modelled with separate input, output and output-enable ports. During data phases the command/byte-enable lines act as per-lane enables, and the target zeroes lanes that are not requested.

Top module: `burst_rd_target`

## Requirements
- R1: While and after reset, with no transaction started, claim_o, tgt_rdy_o and mux_oe are 0 and mux_o is 0.
- R2: A transaction starts on a clock where txn_i is 1 and was 0 on the previous clock. If cmd_be_i[3:0] is 4'b0010 (I/O read) and mux_i lies in the window BASE to BASE+4*WORDS-1, claim_o is 1 from the next cycle on. mux_i[1:0] has no effect on the decode.
- R3: If the starting command is not 4'b0010, or the address is outside the window, claim_o, tgt_rdy_o and mux_oe stay 0 for the whole transaction.
- R4: In the cycle right after a claimed address phase, mux_oe and tgt_rdy_o are 0 and mux_o is 0. mux_oe is 1 from the cycle after that onward.
- R5: Exactly WAIT_CYC cycles with mux_oe at 1 and tgt_rdy_o at 0 pass before tgt_rdy_o first rises.
- R6: A word transfers only on a clock where init_rdy_i and tgt_rdy_o are both 1. While init_rdy_i is 0, the claim and tgt_rdy_o hold and the word on offer does not change.
- R7: The k-th transferred word of a burst is f((i0+k) mod WORDS). Here i0 is mux_i[5:2] at the address phase, and f(i) = 32'h5A5A0F0F XOR (i * 32'h00010003), truncated to 32 bits.
- R8: During a data phase, byte lane j of mux_o (bits 8j+7 down to 8j) carries the word's byte when cmd_be_i[j] is 1 and is zero when it is 0.
- R9: A transfer with txn_i at 0 is the last one. On the next cycle claim_o, tgt_rdy_o and mux_oe are all 0.
- R10: Bursts of four or more phases are served. The word index wraps from WORDS-1 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_i | input | 1 | Transaction active, driven by the initiator |
| init_rdy_i | input | 1 | Initiator ready for a data phase |
| mux_i | input | BUS_W | Shared address/data lines, as seen by the target |
| cmd_be_i | input | BUS_W/8 | Command in the address phase, byte-lane enables in data phases |
| mux_o | output | BUS_W | Read data driven onto the shared lines |
| mux_oe | output | 1 | Output enable for mux_o |
| claim_o | output | 1 | Target has claimed the transaction |
| tgt_rdy_o | output | 1 | Target ready for a data phase |

## Verification
Every start index in the window is swept with four-phase bursts and all lanes enabled. Because the last indices cross the array end, these sweeps separate correct wrapping from plain counting. A second sweep over all indices adds rotating byte-enable patterns and initiator stalls on chosen phases, which exposes a pointer that advances without a handshake or a lane mask applied to the wrong lane. Every non-read command, and the addresses just below and just above the window, are sent to show that the target stays silent. A single-phase read and an eight-phase read bound the burst length.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_WAIT = 2'd2,
        ST_DATA = 2'd3
    } tgt_state_e;

    typedef struct packed {
        logic claim;
        logic drive;
        logic ready;
    } tgt_ctl_t;

    localparam logic [3:0] CMD_IO_READ = 4'b0010;

    function automatic logic [63:0] word_init(input int unsigned idx, input logic [63:0] seed);
        return seed ^ (64'(idx) * 64'h0000_0000_0001_0003);
    endfunction

    function automatic tgt_ctl_t ctl_of(input tgt_state_e st);
        tgt_ctl_t c;
        c.claim = (st != ST_IDLE);
        c.drive = (st == ST_WAIT) || (st == ST_DATA);
        c.ready = (st == ST_DATA);
        return c;
    endfunction

endpackage

// File: rtl/brt_decode.sv
module brt_decode
    import burst_rd_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int IDX_W = 4,
    parameter logic [BUS_W-1:0] BASE = 'h400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle_i,
    input  logic             txn_i,
    input  logic [BUS_W-1:0] mux_i,
    input  logic [3:0]       cmd_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam int TAG_LO = IDX_W + 2;

    logic txn_q;
    logic in_window;
    logic is_read;
    logic unused_low;

    always_ff @(posedge clk) begin
        if (rst) txn_q <= 1'b0;
        else     txn_q <= txn_i;
    end

    assign in_window  = (mux_i[BUS_W-1:TAG_LO] == BASE[BUS_W-1:TAG_LO]);
    assign is_read    = (cmd_i == CMD_IO_READ);
    assign hit_o      = idle_i && txn_i && !txn_q && in_window && is_read;
    assign idx_o      = mux_i[TAG_LO-1:2];
    assign unused_low = ^mux_i[1:0];

endmodule

// File: rtl/brt_fsm.sv
module brt_fsm
    import burst_rd_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     hit_i,
    input  logic     txn_i,
    input  logic     init_rdy_i,
    output logic     idle_o,
    output logic     xfer_o,
    output tgt_ctl_t ctl_o
);
    localparam int CNT_W = $clog2(WAIT_CYC + 2);
    localparam logic [CNT_W-1:0] CNT_LOAD = (WAIT_CYC > 0) ? CNT_W'(WAIT_CYC - 1) : '0;

    tgt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign ctl_o  = ctl_of(state_q);
    assign idle_o = (state_q == ST_IDLE);
    assign xfer_o = (state_q == ST_DATA) && init_rdy_i;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: if (hit_i) state_d = ST_TURN;
            ST_TURN: begin
                if (WAIT_CYC == 0) begin
                    state_d = ST_DATA;
                end else begin
                    state_d = ST_WAIT;
                    cnt_d   = CNT_LOAD;
                end
            end
            ST_WAIT: begin
                if (cnt_q == '0) state_d = ST_DATA;
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_DATA: if (xfer_o && !txn_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/brt_store.sv
module brt_store
    import burst_rd_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int WORDS = 16,
    parameter logic [BUS_W-1:0] SEED = 'h5A5A0F0F
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic [$clog2(WORDS)-1:0] load_idx_i,
    input  logic                 adv_i,
    input  logic [BUS_W/8-1:0]   be_i,
    output logic [BUS_W-1:0]     rd_data_o
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int LANES = BUS_W / 8;

    logic [BUS_W-1:0] mem [WORDS];
    logic [IDX_W-1:0] ptr_q;
    logic [BUS_W-1:0] word;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) begin
                mem[w] <= BUS_W'(word_init(w, 64'(SEED)));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         ptr_q <= '0;
        else if (load_i) ptr_q <= load_idx_i;
        else if (adv_i)  ptr_q <= ptr_q + 1'b1;
    end

    assign word = mem[ptr_q];

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign rd_data_o[8*j +: 8] = be_i[j] ? word[8*j +: 8] : 8'h00;
    end

endmodule

// File: rtl/burst_rd_target.sv
module burst_rd_target
    import burst_rd_pkg::*;
#(
    parameter int BUS_W    = 32,
    parameter int WORDS    = 16,
    parameter int WAIT_CYC = 2,
    parameter logic [BUS_W-1:0] BASE = 'h400,
    parameter logic [BUS_W-1:0] SEED = 'h5A5A0F0F
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               txn_i,
    input  logic               init_rdy_i,
    input  logic [BUS_W-1:0]   mux_i,
    input  logic [BUS_W/8-1:0] cmd_be_i,
    output logic [BUS_W-1:0]   mux_o,
    output logic               mux_oe,
    output logic               claim_o,
    output logic               tgt_rdy_o
);
    localparam int IDX_W = $clog2(WORDS);

    logic             idle;
    logic             hit;
    logic             xfer;
    logic [IDX_W-1:0] start_idx;
    logic [BUS_W-1:0] rd_data;
    tgt_ctl_t         ctl;

    brt_decode #(.BUS_W(BUS_W), .IDX_W(IDX_W), .BASE(BASE)) u_decode (
        .clk    (clk),
        .rst    (rst),
        .idle_i (idle),
        .txn_i  (txn_i),
        .mux_i  (mux_i),
        .cmd_i  (cmd_be_i[3:0]),
        .hit_o  (hit),
        .idx_o  (start_idx)
    );

    brt_fsm #(.WAIT_CYC(WAIT_CYC)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .hit_i      (hit),
        .txn_i      (txn_i),
        .init_rdy_i (init_rdy_i),
        .idle_o     (idle),
        .xfer_o     (xfer),
        .ctl_o      (ctl)
    );

    brt_store #(.BUS_W(BUS_W), .WORDS(WORDS), .SEED(SEED)) u_store (
        .clk        (clk),
        .rst        (rst),
        .load_i     (hit),
        .load_idx_i (start_idx),
        .adv_i      (xfer),
        .be_i       (cmd_be_i),
        .rd_data_o  (rd_data)
    );

    assign claim_o   = ctl.claim;
    assign mux_oe    = ctl.drive;
    assign tgt_rdy_o = ctl.ready;
    assign mux_o     = ctl.drive ? rd_data : '0;

endmodule

// File: rtl/brt_checker.sv
module brt_checker
    import burst_rd_pkg::*;
#(
    parameter int BUS_W    = 32,
    parameter int WAIT_CYC = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               txn_i,
    input logic               init_rdy_i,
    input logic [BUS_W/8-1:0] cmd_be_i,
    input logic [BUS_W-1:0]   mux_o,
    input logic               mux_oe,
    input logic               claim_o,
    input logic               tgt_rdy_o
);
    logic        txn_prev;
    logic        seen_rdy;
    logic [15:0] wait_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            txn_prev  <= 1'b0;
            seen_rdy  <= 1'b0;
            wait_seen <= '0;
        end else begin
            txn_prev <= txn_i;
            if (!claim_o) begin
                seen_rdy  <= 1'b0;
                wait_seen <= '0;
            end else begin
                if (tgt_rdy_o) seen_rdy <= 1'b1;
                if (mux_oe && !tgt_rdy_o && !seen_rdy) wait_seen <= wait_seen + 1'b1;
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !claim_o && !tgt_rdy_o && !mux_oe); // R1

    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!claim_o && txn_i && !txn_prev && cmd_be_i[3:0] != CMD_IO_READ) |=> !claim_o); // R3

    AST_TURN_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        $rose(claim_o) |-> !mux_oe && !tgt_rdy_o && mux_o == '0); // R4

    AST_TURN_THEN_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(claim_o) |=> mux_oe); // R4

    AST_WAIT_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (tgt_rdy_o && !seen_rdy) |-> wait_seen == 16'(WAIT_CYC)); // R5

    AST_HOLD_CLAIM: assert property (@(posedge clk) disable iff (rst)
        (claim_o && !(tgt_rdy_o && init_rdy_i)) |=> claim_o); // R6

    AST_HOLD_READY: assert property (@(posedge clk) disable iff (rst)
        (tgt_rdy_o && !init_rdy_i) |=> tgt_rdy_o); // R6

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (tgt_rdy_o && init_rdy_i && !txn_i) |=> !claim_o && !tgt_rdy_o && !mux_oe); // R9

    AST_READY_CLAIMED: assert property (@(posedge clk) disable iff (rst)
        tgt_rdy_o |-> claim_o && mux_oe); // R6

endmodule

bind burst_rd_target brt_checker #(.BUS_W(BUS_W), .WAIT_CYC(WAIT_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .txn_i      (txn_i),
    .init_rdy_i (init_rdy_i),
    .cmd_be_i   (cmd_be_i),
    .mux_o      (mux_o),
    .mux_oe     (mux_oe),
    .claim_o    (claim_o),
    .tgt_rdy_o  (tgt_rdy_o)
);

// File: tb/burst_rd_target_test.sv
module burst_rd_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 16;
    localparam int WAIT_CYC   = 2;
    localparam logic [31:0] BASE = 32'h0000_0400;
    localparam logic [31:0] SEED = 32'h5A5A_0F0F;
    localparam logic [3:0]  RD   = 4'b0010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        txn_i = 1'b0;
    logic        init_rdy_i = 1'b0;
    logic [31:0] mux_i = '0;
    logic [3:0]  cmd_be_i = '0;
    logic [31:0] mux_o;
    logic        mux_oe;
    logic        claim_o;
    logic        tgt_rdy_o;

    int n_chk  = 0;
    int n_fail = 0;

    burst_rd_target #(.BUS_W(32), .WORDS(WORDS), .WAIT_CYC(WAIT_CYC), .BASE(BASE), .SEED(SEED)) uut (
        .clk(clk), .rst(rst), .txn_i(txn_i), .init_rdy_i(init_rdy_i),
        .mux_i(mux_i), .cmd_be_i(cmd_be_i), .mux_o(mux_o), .mux_oe(mux_oe),
        .claim_o(claim_o), .tgt_rdy_o(tgt_rdy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    function automatic logic [31:0] exp_word(input int i, input logic [3:0] be);
        logic [31:0] w;
        logic [31:0] m;
        w = SEED ^ (32'(i % WORDS) * 32'h0001_0003);
        for (int j = 0; j < 4; j++) m[8*j +: 8] = be[j] ? 8'hFF : 8'h00;
        return w & m;
    endfunction

    // mode 0: all lanes, no stalls; mode 1: rotating lanes and stalls
    task automatic read_burst(input logic [31:0] addr, input int len, input int mode);
        int i0;
        int wcnt;
        logic [3:0] be;
        int stall;
        i0 = int'(addr[5:2]);
        @(negedge clk);
        txn_i = 1'b1; mux_i = addr; cmd_be_i = RD; init_rdy_i = 1'b0;
        @(negedge clk);
        chk(claim_o == 1'b1, "R2 claim after address", 32'(claim_o), 32'd1);
        chk(!mux_oe && !tgt_rdy_o && mux_o == '0, "R4 turnaround undriven", {mux_o[29:0], mux_oe, tgt_rdy_o}, 32'd0);
        mux_i = 32'hDEAD_BEEF; cmd_be_i = 4'hF;
        @(negedge clk);
        wcnt = 0;
        while (!tgt_rdy_o && wcnt < 20) begin
            chk(mux_oe == 1'b1 && claim_o == 1'b1, "R4 drive after turnaround", 32'(mux_oe), 32'd1);
            wcnt++;
            @(negedge clk);
        end
        chk(wcnt == WAIT_CYC, "R5 wait cycle count", 32'(wcnt), 32'(WAIT_CYC));
        for (int k = 0; k < len; k++) begin
            be    = (mode == 0) ? 4'hF : 4'((i0 * 3 + k * 7 + 1) % 16);
            stall = (mode == 1 && ((i0 + k) % 3 == 0)) ? 2 : 0;
            for (int s = 0; s < stall; s++) begin
                init_rdy_i = 1'b0; txn_i = 1'b1; cmd_be_i = be;
                #1;
                chk(tgt_rdy_o && claim_o, "R6 ready held while initiator waits", 32'(tgt_rdy_o), 32'd1);
                @(negedge clk);
            end
            init_rdy_i = 1'b1; txn_i = (k != len - 1); cmd_be_i = be;
            #1;
            chk(mux_o == exp_word(i0 + k, be), (mode == 0) ? "R7 R10 burst word" : "R8 R6 lane-masked word",
                mux_o, exp_word(i0 + k, be));
            @(negedge clk);
        end
        chk(!claim_o && !tgt_rdy_o && !mux_oe && mux_o == '0, "R9 release after last phase",
            {mux_o[28:0], claim_o, tgt_rdy_o, mux_oe}, 32'd0);
        txn_i = 1'b0; init_rdy_i = 1'b0; cmd_be_i = 4'h0; mux_i = '0;
    endtask

    task automatic miss(input logic [31:0] addr, input logic [3:0] cmd);
        @(negedge clk);
        txn_i = 1'b1; mux_i = addr; cmd_be_i = cmd; init_rdy_i = 1'b0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            mux_i = '0; cmd_be_i = 4'hF; init_rdy_i = 1'b1;
            if (c == 5) txn_i = 1'b0;
            #1;
            chk(!claim_o && !tgt_rdy_o && !mux_oe, "R3 no claim on miss",
                {29'd0, claim_o, tgt_rdy_o, mux_oe}, 32'd0);
        end
        @(negedge clk);
        txn_i = 1'b0; init_rdy_i = 1'b0; cmd_be_i = 4'h0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk(!claim_o && !tgt_rdy_o && !mux_oe && mux_o == '0, "R1 reset quiet",
            {mux_o[28:0], claim_o, tgt_rdy_o, mux_oe}, 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!claim_o && !tgt_rdy_o && !mux_oe && mux_o == '0, "R1 idle after reset",
            {mux_o[28:0], claim_o, tgt_rdy_o, mux_oe}, 32'd0);

        for (int i = 0; i < WORDS; i++)
            read_burst(BASE + 32'(4 * i) + 32'(i % 4), 4, 0);   // R2 low bits ignored, R10 wrap
        for (int i = 0; i < WORDS; i++)
            read_burst(BASE + 32'(4 * i), 4, 1);                // R6 R8
        read_burst(BASE + 32'h8, 1, 0);                          // single-phase R9
        read_burst(BASE + 32'h34, 8, 1);                         // long burst R10

        for (int c = 0; c < 16; c++)
            if (4'(c) != RD) miss(BASE, 4'(c));                  // R3 command
        miss(BASE - 32'd4, RD);                                   // R3 below window
        miss(BASE + 32'(4 * WORDS), RD);                         // R3 above window
        read_burst(BASE + 32'h3C, 4, 0);                         // claim still works after misses

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule